// File: doc/BRIEF.md
# Half-Bridge Fault Protection Supervisor

This block sits between a serial control register and the gate drivers of three half-bridges (six switches). It takes the commanded switch word together with synchronous fault flags: one overcurrent flag per switch, one underload flag per bridge, supply undervoltage and overvoltage, thermal prewarning and thermal shutdown. From these it produces the gated switch enables that actually reach the power stage, plus a 16-bit status vector that a serial interface shifts out.

Reactions are selective. A filtered overcurrent turns off only the switch that saw it; supply and thermal faults turn off every switch but leave the stored command intact, so outputs come back by themselves once the fault goes away. Diagnostic bits latch until software clears them with a control write, so short supply dips remain visible afterwards. Delays are counted in system-clock cycles and set by parameters.

Switch index s (0..5) belongs to bridge s/2; even s is the low-side switch, odd s the high-side switch. Control word fields: bit 0 clears the diagnostic latches, bits 6:1 command switches 0..5 (bit s+1, high = on), bit 13 enables overcurrent shutdown, bit 15 enables overvoltage lockout.

Top module: `hb_fault_supervisor`

## Requirements
- R1: A control write (cmd_valid_i high at a clock edge) stores cmd_word_i; from then on, with no fault active, sw_en_o[s] equals control bit s+1.
- R2: When oc_flag_i[s] stays high for OC_DLY_CYC consecutive edges with control bit 13 high, switch s alone goes off after the following edge (OC_DLY_CYC+1 edges after the flag rose); a flag that drops before the count completes restarts it and trips nothing.
- R3: With control bit 13 low, a filtered overcurrent switches nothing off, but still sets status bit 13.
- R4: uv_flag_i high forces all six enables low in the same cycle and sets status bit 15 at the next edge.
- R5: ov_flag_i high forces all enables low only while control bit 15 is high; status bit 15 is set by an overvoltage in either case.
- R6: Supply faults do not alter the stored control word: when the fault clears, the enables return to the commanded state without a new write, while status bit 15 stays set.
- R7: tsd_flag_i high forces all enables low; tw_flag_i only sets status bit 0 and leaves the enables unchanged.
- R8: ul_flag_i[b] held for UL_DLY_CYC consecutive edges sets status bit 14 at the following edge and does not change any enable.
- R9: An overcurrent trip stays latched until the next control write; that write releases the switch and restarts the filters, so a fault still present trips again only after a full OC_DLY_CYC count.
- R10: A control write with bit 0 high clears status bits 15, 14, 13 and 0 at that edge; a fault setting a bit in the same cycle wins over the clear.
- R11: Status bits 6:1 report sw_en_o[5:0] (high = on) and bits 12:7 read zero.
- R12: After reset all enables are low and the status vector is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Control write strobe |
| cmd_word_i | input | 16 | Control word |
| oc_flag_i | input | 6 | Overcurrent flag per switch |
| ul_flag_i | input | 3 | Underload/open-load flag per bridge |
| uv_flag_i | input | 1 | Supply undervoltage |
| ov_flag_i | input | 1 | Supply overvoltage |
| tw_flag_i | input | 1 | Thermal prewarning |
| tsd_flag_i | input | 1 | Thermal shutdown |
| sw_en_o | output | 6 | Gated switch enables |
| status_o | output | 16 | Diagnostic status vector |

## Verification
The bench targets the exact filter boundary: one edge short of the overcurrent and underload counts nothing may change, and one edge later the single affected switch or bit must change, so an off-by-one counter or a filter that does not restart on a dropped flag shows up as an early, late or spurious trip. It checks that a trip on one switch leaves the others running; a design that used a shared trip would kill the whole bridge set. It checks that the protection-enable bits really gate the overcurrent and overvoltage reactions, that outputs come back after undervoltage without rewriting, and that a persistent fault re-trips only after a full count following a rewrite; a design clearing the command on a supply fault or not restarting the filter would fail these.

// File: rtl/hb_sup_pkg.sv
package hb_sup_pkg;
  localparam int NUM_BRIDGE = 3;
  localparam int NUM_SW     = 2 * NUM_BRIDGE;
  localparam int WORD_W     = 16;

  // control word fields
  localparam int CW_CLR    = 0;
  localparam int CW_SW_LSB = 1;
  localparam int CW_OC_EN  = 13;
  localparam int CW_OV_EN  = 15;

  // status word fields
  localparam int ST_TW     = 0;
  localparam int ST_SW_LSB = 1;
  localparam int ST_OVL    = 13;
  localparam int ST_UL     = 14;
  localparam int ST_PF     = 15;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [NUM_SW-1:0] sw_vec_t;
endpackage

// File: rtl/hb_dly_filter.sv
module hb_dly_filter #(
  parameter int DLY_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic flag_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(DLY_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DLY_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (restart_i || !flag_i) cnt_q <= '0;
    else if (cnt_q != CNT_MAX)    cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == CNT_MAX);

  a_r2_flag_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_o |-> $past(flag_i));
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_sup_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    wr_i,
  input  word_t   word_i,
  input  sw_vec_t oc_exp_i,
  input  logic    uv_i,
  input  logic    ov_i,
  input  logic    tsd_i,
  output sw_vec_t sw_en_o
);
  sw_vec_t sw_cmd_q;
  sw_vec_t trip_q;
  logic    oc_en_q;
  logic    ov_en_q;
  logic    global_off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_cmd_q <= '0;
      oc_en_q  <= 1'b0;
      ov_en_q  <= 1'b0;
    end else if (wr_i) begin
      sw_cmd_q <= word_i[CW_SW_LSB +: NUM_SW];
      oc_en_q  <= word_i[CW_OC_EN];
      ov_en_q  <= word_i[CW_OV_EN];
    end
  end

  // a write releases all trips; otherwise trips accumulate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   trip_q <= '0;
    else if (wr_i) trip_q <= '0;
    else           trip_q <= trip_q | (oc_exp_i & {NUM_SW{oc_en_q}});
  end

  assign global_off = uv_i | tsd_i | (ov_i & ov_en_q);
  assign sw_en_o    = global_off ? '0 : (sw_cmd_q & ~trip_q);

  logic unused_w;
  assign unused_w = ^{word_i[CW_CLR], word_i[CW_OC_EN-1:CW_SW_LSB+NUM_SW], word_i[14]};

  a_r3_no_trip_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oc_en_q |-> (trip_q == '0));
  a_r9_write_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (trip_q == '0));
endmodule

// File: rtl/hb_diag_latch.sv
module hb_diag_latch
  import hb_sup_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    clr_i,
  input  logic    uv_i,
  input  logic    ov_i,
  input  logic    tw_i,
  input  logic    ovl_i,
  input  logic    ul_i,
  input  sw_vec_t sw_en_i,
  output word_t   status_o
);
  logic pf_q, ul_q, ovl_q, tw_q;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_q  <= 1'b0;
      ul_q  <= 1'b0;
      ovl_q <= 1'b0;
      tw_q  <= 1'b0;
    end else begin
      pf_q  <= (pf_q  & ~clr_i) | uv_i | ov_i;
      ul_q  <= (ul_q  & ~clr_i) | ul_i;
      ovl_q <= (ovl_q & ~clr_i) | ovl_i;
      tw_q  <= (tw_q  & ~clr_i) | tw_i;
    end
  end

  always_comb begin
    status_o                         = '0;
    status_o[ST_TW]                  = tw_q;
    status_o[ST_SW_LSB +: NUM_SW]    = sw_en_i;
    status_o[ST_OVL]                 = ovl_q;
    status_o[ST_UL]                  = ul_q;
    status_o[ST_PF]                  = pf_q;
  end

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !uv_i && !ov_i && !tw_i && !ovl_i && !ul_i)
      |=> (status_o[ST_PF] == 1'b0 && status_o[ST_UL] == 1'b0 &&
           status_o[ST_OVL] == 1'b0 && status_o[ST_TW] == 1'b0));
  a_r5_supply_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uv_i || ov_i) |=> status_o[ST_PF]);
endmodule

// File: rtl/hb_fault_supervisor.sv
module hb_fault_supervisor
  import hb_sup_pkg::*;
#(
  parameter int OC_DLY_CYC = 1400,
  parameter int UL_DLY_CYC = 18500
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  input  logic [15:0] cmd_word_i,
  input  logic [5:0]  oc_flag_i,
  input  logic [2:0]  ul_flag_i,
  input  logic        uv_flag_i,
  input  logic        ov_flag_i,
  input  logic        tw_flag_i,
  input  logic        tsd_flag_i,
  output logic [5:0]  sw_en_o,
  output logic [15:0] status_o
);
  sw_vec_t                oc_exp;
  logic [NUM_BRIDGE-1:0]  ul_exp;
  logic                   clr_diag;

  assign clr_diag = cmd_valid_i & cmd_word_i[CW_CLR];

  for (genvar s = 0; s < NUM_SW; s++) begin : g_oc
    hb_dly_filter #(.DLY_CYC(OC_DLY_CYC)) u_oc_filt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (cmd_valid_i),
      .flag_i    (oc_flag_i[s]),
      .expired_o (oc_exp[s])
    );
  end

  for (genvar b = 0; b < NUM_BRIDGE; b++) begin : g_ul
    hb_dly_filter #(.DLY_CYC(UL_DLY_CYC)) u_ul_filt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (1'b0),
      .flag_i    (ul_flag_i[b]),
      .expired_o (ul_exp[b])
    );
  end

  hb_gate_ctrl u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (cmd_valid_i),
    .word_i   (cmd_word_i),
    .oc_exp_i (oc_exp),
    .uv_i     (uv_flag_i),
    .ov_i     (ov_flag_i),
    .tsd_i    (tsd_flag_i),
    .sw_en_o  (sw_en_o)
  );

  hb_diag_latch u_diag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_diag),
    .uv_i     (uv_flag_i),
    .ov_i     (ov_flag_i),
    .tw_i     (tw_flag_i),
    .ovl_i    (|oc_exp),
    .ul_i     (|ul_exp),
    .sw_en_i  (sw_en_o),
    .status_o (status_o)
  );

  a_r4_uv_all_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_flag_i |-> (sw_en_o == '0));
  a_r7_tsd_all_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tsd_flag_i |-> (sw_en_o == '0));
  a_r11_status_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[6:1] == sw_en_o) && (status_o[12:7] == '0));
endmodule

// File: tb/tb_hb_fault_supervisor.sv
module tb_hb_fault_supervisor;
  localparam int OC_D = 20;
  localparam int UL_D = 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [5:0]  oc_flag = '0;
  logic [2:0]  ul_flag = '0;
  logic        uv = 1'b0, ov = 1'b0, tw = 1'b0, tsd = 1'b0;
  logic [5:0]  sw_en;
  logic [15:0] status;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hb_fault_supervisor #(.OC_DLY_CYC(OC_D), .UL_DLY_CYC(UL_D)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_word_i(cmd_word),
    .oc_flag_i(oc_flag), .ul_flag_i(ul_flag), .uv_flag_i(uv), .ov_flag_i(ov),
    .tw_flag_i(tw), .tsd_flag_i(tsd), .sw_en_o(sw_en), .status_o(status));

  // control: bit13 OC enable, bit15 OV enable, bits 6:1 switches
  localparam logic [15:0] CW_OC  = 16'h2000;
  localparam logic [15:0] CW_OV  = 16'h8000;
  localparam logic [15:0] SW_SET = 16'b0000_0000_0011_0010; // sw0, sw3, sw4

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_cmd(input logic [15:0] w);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_word = w;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_word = '0;
  endtask

  task automatic t_reset();
    chk("R12 reset enables", {10'd0, sw_en}, 16'h0);
    chk("R12 reset status", status, 16'h0);
  endtask

  task automatic t_cmd();
    write_cmd(CW_OC | 16'h007E);
    chk("R1 all on", {10'd0, sw_en}, 16'h003F);
    chk("R11 mirror all", status, 16'h007E);
    write_cmd(CW_OC | SW_SET);
    chk("R1 pattern", {10'd0, sw_en}, 16'h0019);
    chk("R11 mirror pattern", status, 16'h0032);
  endtask

  task automatic t_oc_glitch();
    @(negedge clk); oc_flag[3] = 1'b1;
    repeat (OC_D - 1) @(negedge clk);
    oc_flag[3] = 1'b0;
    @(negedge clk); oc_flag[3] = 1'b1;
    repeat (OC_D - 1) @(negedge clk);
    oc_flag[3] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 dropped flag no trip", {10'd0, sw_en}, 16'h0019);
    chk("R2 dropped flag no overload", {15'd0, status[13]}, 16'h0);
  endtask

  task automatic t_oc_trip();
    @(negedge clk); oc_flag[0] = 1'b1;
    repeat (OC_D) @(negedge clk);
    chk("R2 before count", {10'd0, sw_en}, 16'h0019);
    @(negedge clk);
    chk("R2 only failing switch off", {10'd0, sw_en}, 16'h0018);
    @(negedge clk);
    chk("R2 overload bit", {15'd0, status[13]}, 16'h1);
    repeat (5) @(negedge clk);
    chk("R9 trip held", {10'd0, sw_en}, 16'h0018);
    // rewrite with fault still present: released, then re-trips after full count
    write_cmd(CW_OC | SW_SET);
    chk("R9 write releases", {10'd0, sw_en}, 16'h0019);
    repeat (OC_D) @(negedge clk);
    chk("R9 no early re-trip", {10'd0, sw_en}, 16'h0019);
    @(negedge clk);
    chk("R9 re-trip", {10'd0, sw_en}, 16'h0018);
    oc_flag[0] = 1'b0;
    write_cmd(CW_OC | SW_SET | 16'h0001);
    chk("R10 clear overload", {15'd0, status[13]}, 16'h0);
    chk("R9 restored", {10'd0, sw_en}, 16'h0019);
  endtask

  task automatic t_oc_disabled();
    write_cmd(SW_SET);
    @(negedge clk); oc_flag[4] = 1'b1;
    repeat (OC_D + 4) @(negedge clk);
    chk("R3 no trip when disabled", {10'd0, sw_en}, 16'h0019);
    chk("R3 overload still flagged", {15'd0, status[13]}, 16'h1);
    oc_flag[4] = 1'b0;
    write_cmd(CW_OC | SW_SET | 16'h0001);
  endtask

  task automatic t_uv();
    @(negedge clk); uv = 1'b1;
    #1 chk("R4 uv all off", {10'd0, sw_en}, 16'h0);
    @(negedge clk);
    chk("R4 supply fail bit", {15'd0, status[15]}, 16'h1);
    uv = 1'b0;
    #1 chk("R6 resume after uv", {10'd0, sw_en}, 16'h0019);
    @(negedge clk);
    chk("R6 supply fail held", {15'd0, status[15]}, 16'h1);
    write_cmd(CW_OC | SW_SET | 16'h0001);
    chk("R10 clear supply fail", {15'd0, status[15]}, 16'h0);
  endtask

  task automatic t_ov();
    @(negedge clk); ov = 1'b1;
    @(negedge clk);
    chk("R5 ov ignored when disabled", {10'd0, sw_en}, 16'h0019);
    chk("R5 ov bit set anyway", {15'd0, status[15]}, 16'h1);
    ov = 1'b0;
    write_cmd(CW_OV | CW_OC | SW_SET | 16'h0001);
    chk("R10 clear after ov", {15'd0, status[15]}, 16'h0);
    @(negedge clk); ov = 1'b1;
    #1 chk("R5 ov lockout", {10'd0, sw_en}, 16'h0);
    @(negedge clk); ov = 1'b0;
    #1 chk("R6 resume after ov", {10'd0, sw_en}, 16'h0019);
    // set wins over clear in same cycle
    @(negedge clk); uv = 1'b1; cmd_valid = 1'b1; cmd_word = CW_OV | CW_OC | SW_SET | 16'h0001;
    @(negedge clk); uv = 1'b0; cmd_valid = 1'b0; cmd_word = '0;
    chk("R10 set wins", {15'd0, status[15]}, 16'h1);
    write_cmd(CW_OV | CW_OC | SW_SET | 16'h0001);
  endtask

  task automatic t_thermal();
    @(negedge clk); tw = 1'b1;
    @(negedge clk);
    chk("R7 prewarn bit", {15'd0, status[0]}, 16'h1);
    chk("R7 prewarn keeps outputs", {10'd0, sw_en}, 16'h0019);
    tw = 1'b0; tsd = 1'b1;
    #1 chk("R7 shutdown all off", {10'd0, sw_en}, 16'h0);
    @(negedge clk); tsd = 1'b0;
    #1 chk("R7 resume after tsd", {10'd0, sw_en}, 16'h0019);
    write_cmd(CW_OV | CW_OC | SW_SET | 16'h0001);
  endtask

  task automatic t_underload();
    @(negedge clk); ul_flag[2] = 1'b1;
    repeat (UL_D) @(negedge clk);
    chk("R8 before count", {15'd0, status[14]}, 16'h0);
    @(negedge clk);
    chk("R8 underload bit", {15'd0, status[14]}, 16'h1);
    chk("R8 outputs unchanged", {10'd0, sw_en}, 16'h0019);
    ul_flag[2] = 1'b0;
    write_cmd(CW_OV | CW_OC | SW_SET | 16'h0001);
    chk("R10 clear underload", status, 16'h0032);
    chk("R11 unused bits zero", {10'd0, status[12:7]}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_cmd();
    t_oc_glitch();
    t_oc_trip();
    t_oc_disabled();
    t_uv();
    t_ov();
    t_thermal();
    t_underload();
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule